// File: doc/BRIEF.md
# Load/Store Queue with Store-to-Load Forwarding

This block keeps the memory operations of an out-of-order core in program order and decides, for each load, where its value comes from. Entries are allocated at dispatch into a circular buffer. The address of an entry arrives later on an address-generation port. The data of a store arrives separately on a store-data port, either before or after its address. Each cycle the queue takes the oldest load whose address is known and does one of three things. It holds the load if an older store still lacks an address. It forwards the data of the youngest older store with the same address. Otherwise it sends the load to the memory read port.

Stores change memory only when they retire at the head of the queue, one per commit, in order. A squash request names a surviving entry, and every entry younger than that one is discarded. Addresses are compared as whole words. Partially overlapping accesses are not merged.

Each entry is a small state machine with four states:
- `E_FREE`: unused. The **alloc** transition takes it to `E_WAIT_AG`.
- `E_WAIT_AG`: waiting for an address. The **agen** transition takes a load, or a store without data, to `E_READY`. A store whose data is already held goes straight to `E_DONE`.
- `E_READY`: the address is known. For a store, the **data** transition takes it to `E_DONE`. For a load, the **issue** transition (forward or memory read) takes it to `E_DONE`.
- `E_DONE`: complete. The **retire** transition takes it back to `E_FREE` when the entry commits at the head.
- From any state, the **kill** transition (squash) returns the entry to `E_FREE`.

Top module: `lsq_fwd`

## Requirements
- R1: After reset the queue is empty: `alloc_ready`=1, `alloc_idx`=0, `commit_ready`=0, and `fwd_valid`, `mem_rd_valid` and `mem_wr_valid` are all 0.
- R2: An accepted allocation takes the entry at `alloc_idx`, and `alloc_idx` then advances by one modulo DEPTH. Once DEPTH entries are held, `alloc_ready` is 0 and further allocation requests are ignored, so `alloc_idx` does not move.
- R3: Suppose a load's address is captured at clock edge k and no older store is in the queue. Then `mem_rd_valid` is 1 with that entry's index and address after edge k+1, and it is never accompanied by `fwd_valid`.
- R4: A load is neither forwarded nor sent to memory while any older store in the queue has no address.
- R5: When one or more older stores hold the load's exact address and the youngest of them has data, `fwd_valid` carries the load's index and that store's data, and no memory read is made.
- R6: When the youngest older matching store has no data yet, the load waits. It is forwarded once that data arrives.
- R7: Older stores with different addresses and all younger stores do not affect a load, which then goes to the memory read port.
- R8: At most one load is decided per cycle, the oldest ready one first, and each load is decided only once.
- R9: `commit_ready` is 1 only when the head entry is complete, and `commit_valid` is ignored otherwise. A store that commits drives `mem_wr_valid` with its address and data on the next cycle; a load that commits drives nothing. Writes leave in program order.
- R10: A squash naming entry s frees every entry younger than s, and `alloc_idx` becomes s+1. Freed entries ignore address and data, and they produce no decision.
- R11: A squash takes priority over an allocation requested in the same cycle, and that allocation is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate an entry at the tail |
| alloc_store | input | 1 | 1 = store, 0 = load |
| alloc_ready | output | 1 | Queue not full |
| alloc_idx | output | 3 | Index the next allocation receives |
| agen_valid | input | 1 | Effective address available |
| agen_idx | input | 3 | Entry receiving the address |
| agen_addr | input | 32 | Effective address |
| sdata_valid | input | 1 | Store data available |
| sdata_idx | input | 3 | Store entry receiving data |
| sdata_value | input | 32 | Store data |
| commit_valid | input | 1 | Retire the head entry |
| commit_ready | output | 1 | Head entry is complete |
| squash_valid | input | 1 | Discard entries younger than squash_idx |
| squash_idx | input | 3 | Youngest surviving entry |
| fwd_valid | output | 1 | Load satisfied by forwarding |
| fwd_idx | output | 3 | Forwarded load entry |
| fwd_data | output | 32 | Forwarded value |
| mem_rd_valid | output | 1 | Load sent to memory |
| mem_rd_idx | output | 3 | Load entry sent |
| mem_rd_addr | output | 32 | Load address |
| mem_wr_valid | output | 1 | Committed store write |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 32 | Write data |

## Verification
Some properties are checked by assertions on every cycle:
- a load is never both forwarded and read from memory;
- the same load is not decided in two consecutive cycles;
- every write follows an accepted commit;
- a squash sets the tail just past the surviving entry;
- a full queue holds its tail when an allocation is refused;
- the occupancy never exceeds the depth.

Other behaviour only the bench scenarios can show: which store's data a load receives, that a load waits behind an unresolved store address or missing store data, that decisions are made oldest first, and that squashed entries stay silent.

// File: rtl/lsq_fwd_pkg.sv
package lsq_fwd_pkg;
    typedef enum logic [1:0] {E_FREE, E_WAIT_AG, E_READY, E_DONE} ent_state_e;
    typedef enum logic [1:0] {ACT_NONE, ACT_FWD, ACT_MEM} ld_act_e;
endpackage

// File: rtl/lsq_fwd_entry.sv
module lsq_fwd_entry
    import lsq_fwd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc,
    input  logic          alloc_store,
    input  logic          kill,
    input  logic          agen_hit,
    input  logic [AW-1:0] agen_addr,
    input  logic          data_hit,
    input  logic [DW-1:0] data_val,
    input  logic          issue,
    input  logic          retire,
    output ent_state_e    state,
    output logic          is_store,
    output logic [AW-1:0] addr,
    output logic          dvalid,
    output logic [DW-1:0] data
);
    ent_state_e    st_q, st_d;
    logic          store_q, dv_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          take_data;

    // A store accepts its data once, in either waiting state.
    assign take_data = data_hit && store_q && !dv_q &&
                       (st_q == E_WAIT_AG || st_q == E_READY);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            E_FREE:    if (alloc) st_d = E_WAIT_AG;
            E_WAIT_AG: if (agen_hit)
                           st_d = (store_q && (dv_q || take_data)) ? E_DONE : E_READY;
            E_READY:   if (store_q ? take_data : issue) st_d = E_DONE;
            E_DONE:    if (retire) st_d = E_FREE;
            default:   st_d = E_FREE;
        endcase
        if (kill) st_d = E_FREE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= E_FREE;
            store_q <= 1'b0;
            dv_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == E_FREE && alloc) begin
                store_q <= alloc_store;
                dv_q    <= 1'b0;
            end else if (take_data) begin
                dv_q   <= 1'b1;
                data_q <= data_val;
            end
            if (st_q == E_WAIT_AG && agen_hit) addr_q <= agen_addr;
        end
    end

    always_comb begin
        state    = st_q;
        is_store = store_q;
        addr     = addr_q;
        dvalid   = dv_q;
        data     = data_q;
    end
endmodule

// File: rtl/lsq_fwd_select.sv
module lsq_fwd_select
    import lsq_fwd_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic [IW-1:0]            head,
    input  ent_state_e [DEPTH-1:0]   st,
    input  logic [DEPTH-1:0]         is_st,
    input  logic [DEPTH-1:0][AW-1:0] addr,
    input  logic [DEPTH-1:0]         dvalid,
    input  logic [DEPTH-1:0][DW-1:0] data,
    output ld_act_e                  act,
    output logic [IW-1:0]            pick_idx,
    output logic [AW-1:0]            pick_addr,
    output logic [DW-1:0]            fwd_data
);
    logic found, blocked, hit, hit_rdy;
    int   p_age;

    always_comb begin
        found     = 1'b0;
        p_age     = 0;
        pick_idx  = '0;
        pick_addr = '0;
        // Oldest load whose address is known.
        for (int a = 0; a < DEPTH; a++) begin
            logic [IW-1:0] ix;
            ix = head + IW'(a);
            if (!found && st[ix] == E_READY && !is_st[ix]) begin
                found     = 1'b1;
                p_age     = a;
                pick_idx  = ix;
                pick_addr = addr[ix];
            end
        end
        // Walk older stores from oldest to youngest; the last match wins.
        blocked  = 1'b0;
        hit      = 1'b0;
        hit_rdy  = 1'b0;
        fwd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            logic [IW-1:0] jx;
            jx = head + IW'(k);
            if (found && k < p_age && is_st[jx] && st[jx] != E_FREE) begin
                if (st[jx] == E_WAIT_AG) begin
                    blocked = 1'b1;
                end else if (addr[jx] == pick_addr) begin
                    hit      = 1'b1;
                    hit_rdy  = dvalid[jx];
                    fwd_data = data[jx];
                end
            end
        end
        if (!found || blocked)  act = ACT_NONE;
        else if (hit)           act = hit_rdy ? ACT_FWD : ACT_NONE;
        else                    act = ACT_MEM;
    end
endmodule

// File: rtl/lsq_fwd.sv
module lsq_fwd
    import lsq_fwd_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    input  logic          alloc_store,
    output logic          alloc_ready,
    output logic [IW-1:0] alloc_idx,
    input  logic          agen_valid,
    input  logic [IW-1:0] agen_idx,
    input  logic [AW-1:0] agen_addr,
    input  logic          sdata_valid,
    input  logic [IW-1:0] sdata_idx,
    input  logic [DW-1:0] sdata_value,
    input  logic          commit_valid,
    output logic          commit_ready,
    input  logic          squash_valid,
    input  logic [IW-1:0] squash_idx,
    output logic          fwd_valid,
    output logic [IW-1:0] fwd_idx,
    output logic [DW-1:0] fwd_data,
    output logic          mem_rd_valid,
    output logic [IW-1:0] mem_rd_idx,
    output logic [AW-1:0] mem_rd_addr,
    output logic          mem_wr_valid,
    output logic [AW-1:0] mem_wr_addr,
    output logic [DW-1:0] mem_wr_data
);
    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] count_q;

    ent_state_e [DEPTH-1:0]   e_st;
    logic [DEPTH-1:0]         e_store, e_dv, kill;
    logic [DEPTH-1:0][AW-1:0] e_addr;
    logic [DEPTH-1:0][DW-1:0] e_data;

    ld_act_e       act;
    logic [IW-1:0] pick_idx, sq_age;
    logic [AW-1:0] pick_addr;
    logic [DW-1:0] sel_data;
    logic          alloc_fire, commit_fire, pick_live;

    assign alloc_ready  = (count_q != CW'(DEPTH));
    assign alloc_idx    = tail_q;
    assign alloc_fire   = alloc_valid && alloc_ready && !squash_valid;
    assign commit_ready = (count_q != '0) && (e_st[head_q] == E_DONE);
    assign commit_fire  = commit_valid && commit_ready;
    assign sq_age       = squash_idx - head_q;
    assign pick_live    = (act != ACT_NONE) && !kill[pick_idx];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic [IW-1:0] rel;
            rel     = IW'(i) - head_q;
            kill[i] = squash_valid && (rel > sq_age);
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        lsq_fwd_entry #(.AW(AW), .DW(DW)) u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc      (alloc_fire && tail_q == IW'(g)),
            .alloc_store(alloc_store),
            .kill       (kill[g]),
            .agen_hit   (agen_valid && agen_idx == IW'(g)),
            .agen_addr  (agen_addr),
            .data_hit   (sdata_valid && sdata_idx == IW'(g)),
            .data_val   (sdata_value),
            .issue      (pick_live && pick_idx == IW'(g)),
            .retire     (commit_fire && head_q == IW'(g)),
            .state      (e_st[g]),
            .is_store   (e_store[g]),
            .addr       (e_addr[g]),
            .dvalid     (e_dv[g]),
            .data       (e_data[g])
        );
    end

    lsq_fwd_select #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_sel (
        .head     (head_q),
        .st       (e_st),
        .is_st    (e_store),
        .addr     (e_addr),
        .dvalid   (e_dv),
        .data     (e_data),
        .act      (act),
        .pick_idx (pick_idx),
        .pick_addr(pick_addr),
        .fwd_data (sel_data)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            head_q <= head_q + IW'(commit_fire);
            if (squash_valid) begin
                tail_q  <= squash_idx + IW'(1);
                count_q <= CW'(sq_age) + CW'(1) - CW'(commit_fire);
            end else begin
                tail_q  <= tail_q + IW'(alloc_fire);
                count_q <= count_q + CW'(alloc_fire) - CW'(commit_fire);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid    <= 1'b0;
            fwd_idx      <= '0;
            fwd_data     <= '0;
            mem_rd_valid <= 1'b0;
            mem_rd_idx   <= '0;
            mem_rd_addr  <= '0;
            mem_wr_valid <= 1'b0;
            mem_wr_addr  <= '0;
            mem_wr_data  <= '0;
        end else begin
            fwd_valid    <= pick_live && act == ACT_FWD;
            fwd_idx      <= pick_idx;
            fwd_data     <= sel_data;
            mem_rd_valid <= pick_live && act == ACT_MEM;
            mem_rd_idx   <= pick_idx;
            mem_rd_addr  <= pick_addr;
            mem_wr_valid <= commit_fire && e_store[head_q];
            mem_wr_addr  <= e_addr[head_q];
            mem_wr_data  <= e_data[head_q];
        end
    end
endmodule

// File: rtl/lsq_fwd_chk.sv
module lsq_fwd_chk #(
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alloc_valid,
    input logic          alloc_ready,
    input logic [IW-1:0] alloc_idx,
    input logic          commit_valid,
    input logic          commit_ready,
    input logic          squash_valid,
    input logic [IW-1:0] squash_idx,
    input logic          fwd_valid,
    input logic [IW-1:0] fwd_idx,
    input logic          mem_rd_valid,
    input logic [IW-1:0] mem_rd_idx,
    input logic          mem_wr_valid,
    input logic [CW-1:0] count_q
);
    a_r3_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        !(fwd_valid && mem_rd_valid));

    a_r8_rd_once: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |=> !(mem_rd_valid && mem_rd_idx == $past(mem_rd_idx)));

    a_r8_fwd_once: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> !(fwd_valid && fwd_idx == $past(fwd_idx)));

    a_r9_wr_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_valid |-> $past(commit_valid && commit_ready));

    a_r10_squash_tail: assert property (@(posedge clk) disable iff (!rst_n)
        squash_valid |=> alloc_idx == IW'($past(squash_idx) + IW'(1)));

    a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_ready && alloc_valid && !squash_valid && !(commit_valid && commit_ready))
        |=> $stable(alloc_idx));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));
endmodule

bind lsq_fwd lsq_fwd_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .alloc_ready (alloc_ready),
    .alloc_idx   (alloc_idx),
    .commit_valid(commit_valid),
    .commit_ready(commit_ready),
    .squash_valid(squash_valid),
    .squash_idx  (squash_idx),
    .fwd_valid   (fwd_valid),
    .fwd_idx     (fwd_idx),
    .mem_rd_valid(mem_rd_valid),
    .mem_rd_idx  (mem_rd_idx),
    .mem_wr_valid(mem_wr_valid),
    .count_q     (count_q)
);

// File: tb/lsq_fwd_bench.sv
module lsq_fwd_bench;
    localparam int DEPTH = 8;
    localparam int AW    = 16;
    localparam int DW    = 16;
    localparam int IW    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_valid = 0, alloc_store = 0, agen_valid = 0, sdata_valid = 0;
    logic commit_valid = 0, squash_valid = 0;
    logic [IW-1:0] agen_idx = '0, sdata_idx = '0, squash_idx = '0;
    logic [AW-1:0] agen_addr = '0;
    logic [DW-1:0] sdata_value = '0;
    logic alloc_ready, commit_ready, fwd_valid, mem_rd_valid, mem_wr_valid;
    logic [IW-1:0] alloc_idx, fwd_idx, mem_rd_idx;
    logic [DW-1:0] fwd_data, mem_wr_data;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;

    int checks = 0, failures = 0;
    int n_fwd = 0, n_rd = 0, n_wr = 0;
    logic [IW-1:0] l_fwd_idx, l_rd_idx, p_rd_idx;
    logic [DW-1:0] l_fwd_data, l_wr_data;
    logic [AW-1:0] l_rd_addr, l_wr_addr;

    // {store address, store data, load address}
    localparam logic [47:0] VEC [4] = '{
        48'h0100_AAAA_0100, 48'h0104_BBBB_0108,
        48'h0200_CCCC_0200, 48'h0300_DDDD_0304 };

    always #5 clk = ~clk;

    lsq_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_lsq_fwd (.*);

    always @(negedge clk) begin
        if (fwd_valid) begin n_fwd++; l_fwd_idx = fwd_idx; l_fwd_data = fwd_data; end
        if (mem_rd_valid) begin n_rd++; p_rd_idx = l_rd_idx; l_rd_idx = mem_rd_idx; l_rd_addr = mem_rd_addr; end
        if (mem_wr_valid) begin n_wr++; l_wr_addr = mem_wr_addr; l_wr_data = mem_wr_data; end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick(); @(posedge clk); #1; endtask
    task automatic wait_cyc(input int n); repeat (n) tick(); endtask

    task automatic do_alloc(input logic st, output logic [IW-1:0] idx);
        idx = alloc_idx; alloc_valid = 1; alloc_store = st; tick(); alloc_valid = 0;
    endtask
    task automatic do_agen(input logic [IW-1:0] idx, input logic [AW-1:0] a);
        agen_valid = 1; agen_idx = idx; agen_addr = a; tick(); agen_valid = 0;
    endtask
    task automatic do_data(input logic [IW-1:0] idx, input logic [DW-1:0] d);
        sdata_valid = 1; sdata_idx = idx; sdata_value = d; tick(); sdata_valid = 0;
    endtask
    task automatic do_commit();
        commit_valid = 1; tick(); commit_valid = 0; wait_cyc(2);
    endtask

    initial begin
        logic [IW-1:0] s0, s1, s2, l0, l1, h, t;
        int f0, r0, w0;
        wait_cyc(3);
        rst_n = 1;
        wait_cyc(2);
        // R1 reset state
        chk("R1", "alloc_ready", alloc_ready, 1);
        chk("R1", "alloc_idx", alloc_idx, 0);
        chk("R1", "commit_ready", commit_ready, 0);
        chk("R1", "outputs idle", {fwd_valid, mem_rd_valid, mem_wr_valid}, 0);

        // R3: lone load goes to memory two edges after its address
        do_alloc(0, l0);
        chk("R2", "alloc_idx advances", alloc_idx, 1);
        do_agen(l0, 16'h0040);
        tick();
        chk("R3", "mem_rd_valid at k+1", mem_rd_valid, 1);
        chk("R3", "mem_rd_addr", mem_rd_addr, 16'h0040);
        chk("R3", "no fwd", fwd_valid, 0);
        w0 = n_wr; do_commit();
        chk("R9", "load commit writes nothing", n_wr, w0);

        // Table: one store then one load, match decides forward vs memory (R5, R7)
        for (int v = 0; v < 4; v++) begin
            logic [AW-1:0] sa, la; logic [DW-1:0] sd;
            sa = VEC[v][47:32]; sd = VEC[v][31:16]; la = VEC[v][15:0];
            f0 = n_fwd; r0 = n_rd; w0 = n_wr;
            do_alloc(1, s0); do_alloc(0, l0);
            do_data(s0, sd); do_agen(s0, sa); do_agen(l0, la);
            wait_cyc(3);
            if (sa == la) begin
                chk("R5", "table fwd count", n_fwd, f0 + 1);
                chk("R5", "table fwd data", l_fwd_data, sd);
                chk("R5", "table no mem read", n_rd, r0);
            end else begin
                chk("R7", "table mem read count", n_rd, r0 + 1);
                chk("R7", "table mem addr", l_rd_addr, la);
            end
            do_commit();
            chk("R9", "table store write addr", l_wr_addr, sa);
            chk("R9", "table store write data", l_wr_data, sd);
            do_commit();
            chk("R9", "table write count", n_wr, w0 + 1);
        end

        // R4: load blocked behind a store without an address
        f0 = n_fwd; r0 = n_rd; w0 = n_wr;
        do_alloc(1, s0); do_alloc(0, l0);
        do_agen(l0, 16'h0500); do_data(s0, 16'h1234);
        wait_cyc(4);
        chk("R4", "no decision while store address unknown", n_fwd + n_rd, f0 + r0);
        chk("R9", "commit_ready low on pending head", commit_ready, 0);
        commit_valid = 1; tick(); commit_valid = 0; wait_cyc(2);
        chk("R9", "commit ignored when not ready", n_wr, w0);
        do_agen(s0, 16'h0500);
        wait_cyc(3);
        chk("R4", "forward after release", n_fwd, f0 + 1);
        chk("R4", "forward idx", l_fwd_idx, l0);
        chk("R4", "forward data", l_fwd_data, 16'h1234);
        do_commit(); do_commit();

        // R6: matching store without data holds the load
        f0 = n_fwd; r0 = n_rd;
        do_alloc(1, s0); do_alloc(0, l0);
        do_agen(s0, 16'h0600); do_agen(l0, 16'h0600);
        wait_cyc(4);
        chk("R6", "load waits for store data", n_fwd + n_rd, f0 + r0);
        do_data(s0, 16'h5A5A);
        wait_cyc(3);
        chk("R6", "forward after data", n_fwd, f0 + 1);
        chk("R6", "forward data", l_fwd_data, 16'h5A5A);
        do_commit(); do_commit();

        // R5 youngest older match wins; R7 younger store ignored
        f0 = n_fwd; w0 = n_wr;
        do_alloc(1, s0); do_alloc(1, s1); do_alloc(0, l0); do_alloc(1, s2);
        do_agen(s2, 16'h0700); do_data(s2, 16'h3333);
        do_data(s0, 16'h1111); do_data(s1, 16'h2222);
        do_agen(s0, 16'h0700); do_agen(s1, 16'h0700); do_agen(l0, 16'h0700);
        wait_cyc(3);
        chk("R5", "youngest older store data", l_fwd_data, 16'h2222);
        chk("R7", "younger store ignored, single fwd", n_fwd, f0 + 1);
        do_commit(); do_commit(); do_commit(); do_commit();
        chk("R9", "three writes", n_wr, w0 + 3);
        chk("R9", "last write is youngest store", l_wr_data, 16'h3333);

        // R8: two loads released together, oldest first
        r0 = n_rd;
        do_alloc(1, s0); do_alloc(0, l0); do_alloc(0, l1);
        do_agen(l1, 16'h0810); do_agen(l0, 16'h0800); do_data(s0, 16'h0);
        wait_cyc(3);
        chk("R4", "both loads held", n_rd, r0);
        do_agen(s0, 16'h0900);
        wait_cyc(4);
        chk("R8", "two reads", n_rd, r0 + 2);
        chk("R8", "older load first", p_rd_idx, l0);
        chk("R8", "younger load second", l_rd_idx, l1);
        do_commit(); do_commit(); do_commit();

        // R2 full; R10 squash
        h = alloc_idx;
        for (int i = 0; i < DEPTH; i++) do_alloc(0, t);
        chk("R2", "full alloc_ready", alloc_ready, 0);
        do_alloc(0, t);
        chk("R2", "alloc ignored when full", alloc_idx, h);
        r0 = n_rd;
        do_agen(h, 16'h0A00); do_agen(h + 3'd1, 16'h0A04);
        squash_valid = 1; squash_idx = h + 3'd1; tick(); squash_valid = 0;
        chk("R10", "alloc_idx after squash", alloc_idx, h + 3'd2);
        chk("R10", "alloc_ready after squash", alloc_ready, 1);
        do_agen(h + 3'd4, 16'h0A10);
        wait_cyc(4);
        chk("R10", "squashed entry silent", n_rd, r0 + 2);
        do_commit(); do_commit();
        chk("R9", "empty after drain", commit_ready, 0);

        // R11: squash beats allocation
        do_alloc(0, l0);
        alloc_valid = 1; alloc_store = 0; squash_valid = 1; squash_idx = l0; tick();
        alloc_valid = 0; squash_valid = 0;
        chk("R11", "alloc dropped under squash", alloc_idx, l0 + 3'd1);
        do_agen(l0, 16'h0B00);
        wait_cyc(3);
        do_commit();
        chk("R11", "queue empty", commit_ready, 0);

        summary();
    end
endmodule